// File: doc/BRIEF.md
# Latched-Address One-of-Eight Decoder

This block turns a binary address into a one-of-N select bus. Outputs are active low, and at most one output is low at any time. The address passes through a hold stage before it reaches the decoder. While the hold control is low, the hold stage is transparent and the outputs follow the live address in the same cycle. When the hold control is high, the outputs show the address that was captured at the last clock edge before the control rose. Later changes on the address pins are then ignored.

Two output enables gate the whole bus: one is active low and one is active high. They act whatever the hold stage is doing, and they never change the stored address. The design is synchronous. The hold stage is a register that reloads on every clock edge while the hold control is low. The effective address is chosen between the live pins and that register, so no latch is inferred.

A parameter selects a two-level cascade. In the cascade, the address is six bits wide. A first-level decoder takes the upper three bits and the external enables. Its active-low outputs enable eight second-level decoders, which share one hold control. Together they give a 64-output decoder with a stored address.

Top module: `hold_addr_decoder`

## Requirements
- R1: While `freeze_i` is 0, `sel_n_o` decodes the live `addr_i` in the same cycle, with no clock edge needed.
- R2: When `freeze_i` is first seen at 1 on a clock edge, the held address is the value `addr_i` had at the previous clock edge.
- R3: While `freeze_i` stays 1, changes on `addr_i` do not affect `sel_n_o`.
- R4: Every bit of `sel_n_o` is 1 unless `en_lo_n_i` is 0 and `en_hi_i` is 1.
- R5: Turning the outputs off and back on while `freeze_i` is 1 leaves the held address, and so the selected output, unchanged.
- R6: When enabled, exactly one bit `sel_n_o[k]` is 0, where k is the effective address read as an unsigned number with `addr_i[0]` as its least significant bit. All other bits are 1.
- R7: A synchronous `rst_i` clears the held address to 0. Reset does not force the outputs: with `freeze_i` at 1 after reset, output 0 is selected if enabled, and all outputs are 1 if not.
- R8: With `CASCADE`=1, the address is 6 bits wide and `sel_n_o` has 64 bits. Bits [5:3] pick the group of eight outputs and bits [2:0] pick the output within the group, so the selected bit index equals the full address. The hold and enable rules above apply unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous reset, active high; clears the held address |
| addr_i | input | ADDR_W (3, or 6 when cascaded) | Binary address, bit 0 least significant |
| freeze_i | input | 1 | 0: hold stage transparent; 1: hold the captured address |
| en_lo_n_i | input | 1 | Output enable, active low |
| en_hi_i | input | 1 | Output enable, active high |
| sel_n_o | output | OUT_W (8, or 64 when cascaded) | One-of-N select, active low |

## Verification
All eight addresses are swept against all four enable combinations while the hold stage is transparent. This shows whether the index is mapped correctly and whether either enable polarity is inverted. Directed sequences then capture an address, move the live pins, and toggle the enables while the address is held. These separate a correct capture from a stage that stays transparent, and from an enable that wrongly clears the stored value. Checks during reset show that the stored address goes to zero while the enables still act. Seeded random runs mix hold, address and enable changes on a plain instance and a cascaded instance side by side. The cascaded instance is also swept over all 64 addresses, which would expose swapped group and in-group address fields.

// File: rtl/hdec_pkg.sv
package hdec_pkg;

  // Both enables must be asserted for any output to go low.
  function automatic logic gate_open(input logic en_lo_n, input logic en_hi);
    return (!en_lo_n) && en_hi;
  endfunction

  // Total address width for a leaf width and cascade depth.
  function automatic int total_addr_w(input int seg_w, input int cascade);
    return seg_w * (cascade + 1);
  endfunction

  // Select the effective address: live pins when transparent, register when held.
  function automatic logic [15:0] pick_addr(input logic frz,
                                            input logic [15:0] live,
                                            input logic [15:0] held);
    return frz ? held : live;
  endfunction

endpackage

// File: rtl/hdec_hold.sv
module hdec_hold #(
  parameter int W = 3
) (
  input  logic         clk_i,
  input  logic         rst_i,
  input  logic [W-1:0] addr_i,
  input  logic         freeze_i,
  output logic [W-1:0] held_o,
  output logic [W-1:0] eff_o
);
  import hdec_pkg::*;

  logic [W-1:0] held_q;
  logic [15:0]  live_x;
  logic [15:0]  held_x;
  logic [15:0]  eff_x;

  // Reload on every edge while transparent; keep the value while frozen.
  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      held_q <= '0;
    end else if (!freeze_i) begin
      held_q <= addr_i;
    end
  end

  always_comb begin
    live_x = '0;
    held_x = '0;
    live_x[W-1:0] = addr_i;
    held_x[W-1:0] = held_q;
    eff_x = pick_addr(freeze_i, live_x, held_x);
  end

  assign held_o = held_q;
  assign eff_o  = eff_x[W-1:0];

endmodule

// File: rtl/hdec_leaf.sv
module hdec_leaf #(
  parameter int SEG_W = 3,
  localparam int N = 1 << SEG_W
) (
  input  logic [SEG_W-1:0] seg_i,
  input  logic             en_lo_n_i,
  input  logic             en_hi_i,
  output logic [N-1:0]     sel_n_o
);
  import hdec_pkg::*;

  logic open_w;
  assign open_w = gate_open(en_lo_n_i, en_hi_i);

  always_comb begin
    for (int k = 0; k < N; k++) begin
      sel_n_o[k] = !(open_w && (seg_i == SEG_W'(k)));
    end
  end

endmodule

// File: rtl/hold_addr_decoder.sv
module hold_addr_decoder #(
  parameter int SEG_W   = 3,
  parameter int CASCADE = 0,
  localparam int ADDR_W = SEG_W * (CASCADE + 1),
  localparam int OUT_W  = 1 << ADDR_W
) (
  input  logic              clk_i,
  input  logic              rst_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              freeze_i,
  input  logic              en_lo_n_i,
  input  logic              en_hi_i,
  output logic [OUT_W-1:0]  sel_n_o
);
  localparam int LEAF_N = 1 << SEG_W;

  // Named internal events for the checker.
  logic [ADDR_W-1:0] held_addr;
  logic [ADDR_W-1:0] eff_addr;

  hdec_hold #(.W(ADDR_W)) u_hold (
    .clk_i    (clk_i),
    .rst_i    (rst_i),
    .addr_i   (addr_i),
    .freeze_i (freeze_i),
    .held_o   (held_addr),
    .eff_o    (eff_addr)
  );

  generate
    if (CASCADE == 0) begin : g_single
      hdec_leaf #(.SEG_W(SEG_W)) u_leaf (
        .seg_i     (eff_addr),
        .en_lo_n_i (en_lo_n_i),
        .en_hi_i   (en_hi_i),
        .sel_n_o   (sel_n_o)
      );
    end else begin : g_cascade
      logic [LEAF_N-1:0] grp_n;

      // First level: upper field, gated by the external enables.
      hdec_leaf #(.SEG_W(SEG_W)) u_top (
        .seg_i     (eff_addr[ADDR_W-1:SEG_W]),
        .en_lo_n_i (en_lo_n_i),
        .en_hi_i   (en_hi_i),
        .sel_n_o   (grp_n)
      );

      // Second level: each group enabled by one first-level output.
      for (genvar g = 0; g < LEAF_N; g++) begin : g_grp
        hdec_leaf #(.SEG_W(SEG_W)) u_sub (
          .seg_i     (eff_addr[SEG_W-1:0]),
          .en_lo_n_i (grp_n[g]),
          .en_hi_i   (1'b1),
          .sel_n_o   (sel_n_o[g*LEAF_N +: LEAF_N])
        );
      end
    end
  endgenerate

endmodule

// File: rtl/hdec_checker.sv
module hdec_checker #(
  parameter int ADDR_W = 3,
  parameter int OUT_W  = 8
) (
  input logic              clk_i,
  input logic              rst_i,
  input logic [ADDR_W-1:0] addr_i,
  input logic              freeze_i,
  input logic              en_lo_n_i,
  input logic              en_hi_i,
  input logic [OUT_W-1:0]  sel_n_o,
  input logic [ADDR_W-1:0] held_addr,
  input logic [ADDR_W-1:0] eff_addr
);

  assert_gated_off_R4: assert property (@(posedge clk_i) disable iff (rst_i)
    !((!en_lo_n_i) && en_hi_i) |-> (sel_n_o == {OUT_W{1'b1}}));

  assert_one_low_R6: assert property (@(posedge clk_i) disable iff (rst_i)
    ((!en_lo_n_i) && en_hi_i) |-> ($countones(~sel_n_o) == 1 && !sel_n_o[eff_addr]));

  assert_follow_live_R1: assert property (@(posedge clk_i) disable iff (rst_i)
    ((!freeze_i) && (!en_lo_n_i) && en_hi_i) |-> !sel_n_o[addr_i]);

  assert_capture_R2: assert property (@(posedge clk_i) disable iff (rst_i)
    ($rose(freeze_i) && !$past(rst_i)) |-> (held_addr == $past(addr_i)));

  // R3 and R5: a frozen held address never moves, whatever the pins or enables do.
  assert_held_stable_R3: assert property (@(posedge clk_i) disable iff (rst_i)
    (freeze_i && $past(freeze_i)) |-> $stable(held_addr));

  assert_reset_clear_R7: assert property (@(posedge clk_i) disable iff (rst_i)
    $past(rst_i) |-> (held_addr == '0));

endmodule

bind hold_addr_decoder hdec_checker #(.ADDR_W(ADDR_W), .OUT_W(OUT_W)) u_chk (
  .clk_i     (clk_i),
  .rst_i     (rst_i),
  .addr_i    (addr_i),
  .freeze_i  (freeze_i),
  .en_lo_n_i (en_lo_n_i),
  .en_hi_i   (en_hi_i),
  .sel_n_o   (sel_n_o),
  .held_addr (held_addr),
  .eff_addr  (eff_addr)
);

// File: tb/test_hold_addr_decoder.sv
`timescale 1ns/1ps
module test_hold_addr_decoder;

  logic        clk = 1'b0;
  logic        rst;
  logic        freeze;
  logic        en_lo_n;
  logic        en_hi;
  logic [2:0]  a_n;
  logic [5:0]  a_w;
  logic [7:0]  sel_n;
  logic [63:0] sel_w;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  // Bench-side view of the stored addresses.
  logic [2:0] mh_n;
  logic [5:0] mh_w;

  always #2.5 clk = ~clk;

  hold_addr_decoder #(.SEG_W(3), .CASCADE(0)) i_hold_addr_decoder (
    .clk_i(clk), .rst_i(rst), .addr_i(a_n), .freeze_i(freeze),
    .en_lo_n_i(en_lo_n), .en_hi_i(en_hi), .sel_n_o(sel_n));

  hold_addr_decoder #(.SEG_W(3), .CASCADE(1)) i_hold_addr_decoder_wide (
    .clk_i(clk), .rst_i(rst), .addr_i(a_w), .freeze_i(freeze),
    .en_lo_n_i(en_lo_n), .en_hi_i(en_hi), .sel_n_o(sel_w));

  always @(posedge clk) begin
    if (rst) begin
      mh_n <= '0;
      mh_w <= '0;
    end else if (!freeze) begin
      mh_n <= a_n;
      mh_w <= a_w;
    end
  end

  // Expected active-low bus: only index idx low, and only when both enables are on.
  function automatic logic [63:0] want(input int idx, input logic lo_n,
                                       input logic hi, input int width);
    logic [63:0] r;
    r = '1;
    if (!lo_n && hi) r[idx] = 1'b0;
    for (int k = width; k < 64; k++) r[k] = 1'b1;
    return r;
  endfunction

  task automatic check(input string req, input logic [63:0] got, input logic [63:0] exp);
    checks++;
    if (got !== exp) begin
      failures++;
      $display("FAIL %s got=%h exp=%h", req, got, exp);
    end
  endtask

  // Drive at the falling edge, check the combinational outputs 1 ns later.
  task automatic step(input string req, input logic [2:0] an, input logic [5:0] aw,
                      input logic frz, input logic lo_n, input logic hi);
    int en, ew;
    @(negedge clk);
    a_n = an; a_w = aw; freeze = frz; en_lo_n = lo_n; en_hi = hi;
    #1;
    en = frz ? int'(mh_n) : int'(an);
    ew = frz ? int'(mh_w) : int'(aw);
    check(req, {56'hFF_FFFF_FFFF_FFFF, sel_n}, want(en, lo_n, hi, 8));
    check({req, "/R8"}, sel_w, want(ew, lo_n, hi, 64));
  endtask

  initial begin
    void'($urandom(32'd4242));
    rst = 1'b1; freeze = 1'b1; en_lo_n = 1'b0; en_hi = 1'b1; a_n = 3'd6; a_w = 6'd41;
    repeat (2) @(posedge clk);
    // R7: held address cleared, outputs still follow enables during reset.
    step("R7", 3'd6, 6'd41, 1'b1, 1'b0, 1'b1);
    step("R7", 3'd6, 6'd41, 1'b1, 1'b1, 1'b1);
    step("R7", 3'd5, 6'd22, 1'b1, 1'b0, 1'b0);
    @(negedge clk); rst = 1'b0;
    step("R7", 3'd3, 6'd9, 1'b1, 1'b0, 1'b1);

    // R1 R4 R6: sweep addresses against every enable combination, transparent.
    for (int a = 0; a < 8; a++) begin
      for (int e = 0; e < 4; e++) begin
        step("R1_R4_R6", 3'(a), 6'(a * 9), 1'b0, e[0], e[1]);
      end
    end

    // R2 R3: capture 5, then move the pins while frozen.
    step("R1", 3'd5, 6'd45, 1'b0, 1'b0, 1'b1);
    step("R2", 3'd2, 6'd7, 1'b1, 1'b0, 1'b1);
    step("R3", 3'd0, 6'd63, 1'b1, 1'b0, 1'b1);
    step("R3", 3'd7, 6'd0, 1'b1, 1'b0, 1'b1);
    // R5: outputs off and on again while frozen.
    step("R5", 3'd1, 6'd12, 1'b1, 1'b1, 1'b1);
    step("R5", 3'd4, 6'd30, 1'b1, 1'b0, 1'b0);
    step("R5", 3'd6, 6'd50, 1'b1, 1'b0, 1'b1);
    // Reopen and confirm the live pins take over again.
    step("R1", 3'd6, 6'd50, 1'b0, 1'b0, 1'b1);

    // R8: full 64-output sweep on the cascaded instance.
    for (int a = 0; a < 64; a++) begin
      step("R8", 3'(a), 6'(a), 1'b0, 1'b0, 1'b1);
    end
    step("R8", 3'd1, 6'd58, 1'b0, 1'b0, 1'b1);
    step("R8", 3'd2, 6'd3, 1'b1, 1'b0, 1'b1);

    // Random mix on both instances.
    for (int i = 0; i < 400; i++) begin
      step("R6_rand", 3'($urandom), 6'($urandom), ($urandom % 3) == 0,
           ($urandom % 4) == 0, ($urandom % 4) != 0);
    end

    done = 1'b1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule